// File: doc/BRIEF.md
# Console UART Register Front-End

This block is the register face of a simple serial console. A CPU reaches it through a byte-wide bus with a three-bit offset, and characters reach the block over a valid/ready stream on the receive side and leave it over a one-cycle valid pulse on the transmit side. No bit timing is modelled. The block holds one received character, an interrupt-enable register, a pointer register that selects how the status offset reads, and two pending flags: one for transmit and one for receive. A single interrupt line is the OR of those two flags.

Bus reads are combinational: `bus_rdata` reflects the addressed register in the same cycle that `bus_valid` is high with `bus_we` low. Any side effect of that access takes effect at the next rising clock edge, including clearing the held character, accepting a new one, or resetting the pointer. Each write to the data offset clears transmit pending and starts a countdown of `TX_DELAY` cycles. When the countdown ends, transmit pending is raised again, provided the transmit-empty enable is set at that moment. The enable register reads back only as `0x0F` or zero, which is enough for a driver probing whether the port exists.

Top module: `console_uart_regs`

## Requirements
- R1: After reset, every register and flag is zero. `irq`, `tx_valid`, `rx_ready` and `ack_err` are low, offset 2 reads 0x01, and offset 5 reads 0x64.
- R2: A read at offset 0 returns the held character. From the next cycle on, the held flag is clear, so receive pending drops.
- R3: A write at offset 0 with a byte below 0x80 other than 0x0C makes `tx_valid` high for exactly the one cycle after the write, with `tx_data` equal to the byte. A byte of 0x0C, or any byte of 0x80 and above, produces no `tx_valid`.
- R4: Every write at offset 0 clears transmit pending and (re)starts a countdown. Exactly `TX_DELAY` clock edges after the write edge, transmit pending is set if bit 1 of the enable register is set at that time. A later data write restarts the count from the beginning.
- R5: A write at offset 1 loads the enable register. If bit 1 of the written byte is set, transmit pending is high in the next cycle. Otherwise transmit pending is cleared and any running countdown is cancelled, so no later expiry sets it.
- R6: A read at offset 1 returns 0x0F when the enable register holds exactly 0x0F, and 0x00 for every other value.
- R7: A read at offset 2 returns 0x00 while transmit or receive is pending, and 0x01 otherwise. Bits 7:1 are always zero.
- R8: A write at offset 3 stores the byte in the pointer register. The byte 0x28 clears transmit pending. If transmit was not pending, `ack_err` is high for the one cycle after that write.
- R9: A read at offset 5 while the pointer is 3 returns 0x10 if transmit is pending, otherwise 0x20 if a character is available, and otherwise 0x00. The pointer reads as 0 afterwards.
- R10: A read at offset 5 with the pointer other than 3 returns 0x64, with bit 0 also set when a character is available.
- R11: During a read at offset 5 with no character held, `rx_ready` is high. An offered character is captured at that edge and counts as available for that read's data. While a character is held, `rx_ready` stays low and the held character is not overwritten.
- R12: Writes at offset 4 change no state. Reads at offsets 3, 4, 6 and 7 return 0x00. `irq` is high exactly when transmit or receive is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| rx_valid | input | 1 | Receive character offered |
| rx_data | input | 8 | Offered character |
| rx_ready | output | 1 | Offered character is taken at this edge |
| tx_valid | output | 1 | Transmit character pulse |
| tx_data | output | 8 | Transmit character |
| irq | output | 1 | Interrupt request |
| ack_err | output | 1 | Pulse: acknowledge with no transmit pending |

## Verification
A wrong pending flag shows on `irq` in the cycle after the access that should have set or cleared it. The same flag shows on a read of offset 2, and on an indirect status read with the pointer at 3, on that read's own cycle. A countdown that is off by even one cycle shows as `irq` rising one edge early or late against the exact edge named in R4. A held-character flag that fails to clear shows immediately in bit 0 of the offset 5 read. A stale held byte shows on the next offset 0 read.

// File: rtl/console_uart_pkg.sv
package console_uart_pkg;

    localparam int DW     = 8;
    localparam int AW     = 3;

    localparam logic [AW-1:0] OFS_DATA = 3'd0;
    localparam logic [AW-1:0] OFS_IEN  = 3'd1;
    localparam logic [AW-1:0] OFS_IID  = 3'd2;
    localparam logic [AW-1:0] OFS_PTR  = 3'd3;
    localparam logic [AW-1:0] OFS_MCTL = 3'd4;
    localparam logic [AW-1:0] OFS_STAT = 3'd5;

    localparam int            TXE_BIT    = 1;
    localparam logic [DW-1:0] CMD_TX_ACK = 8'h28;
    localparam logic [DW-1:0] PTR_SRC    = 8'h03;
    localparam logic [DW-1:0] BYTE_FF    = 8'h0C;
    localparam logic [DW-1:0] PROBE_VAL  = 8'h0F;
    localparam logic [DW-1:0] STAT_IDLE  = 8'h64;
    localparam logic [DW-1:0] SRC_TX     = 8'h10;
    localparam logic [DW-1:0] SRC_RX     = 8'h20;

    typedef struct packed {
        logic [DW-1:0] ier;
        logic [DW-1:0] ptr;
        logic          tx_pend;
        logic          tx_vld;
        logic [DW-1:0] tx_byte;
        logic          ack_bad;
    } core_t;

    function automatic logic is_emittable(input logic [DW-1:0] b);
        return (b[DW-1] == 1'b0) && (b != BYTE_FF);
    endfunction

endpackage

// File: rtl/cu_txe_timer.sv
module cu_txe_timer #(
    parameter int DELAY = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expire
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DELAY);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cancel) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    assign expire = (cnt_q == ONE) && !start && !cancel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cu_rx_hold.sv
module cu_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] take_data,
    input  logic         consume,
    output logic         held,
    output logic [W-1:0] held_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.dat = take_data;
        end else if (consume) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held      = st_q.vld;
    assign held_data = st_q.dat;
endmodule

// File: rtl/cu_read_mux.sv
module cu_read_mux
    import console_uart_pkg::*;
(
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] ier,
    input  logic [DW-1:0] ptr,
    input  logic          tx_pend,
    input  logic          rx_avail,
    input  logic [DW-1:0] held_data,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] stat_val;

    always_comb begin
        if (ptr == PTR_SRC) begin
            if (tx_pend)       stat_val = SRC_TX;
            else if (rx_avail) stat_val = SRC_RX;
            else               stat_val = '0;
        end else begin
            stat_val = STAT_IDLE | {{(DW-1){1'b0}}, rx_avail};
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_DATA: rdata = held_data;
                OFS_IEN:  rdata = (ier == PROBE_VAL) ? PROBE_VAL : '0;
                OFS_IID:  rdata = {{(DW-1){1'b0}}, !(tx_pend || rx_avail)};
                OFS_STAT: rdata = stat_val;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/console_uart_regs.sv
module console_uart_regs
    import console_uart_pkg::*;
#(
    parameter int TX_DELAY = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          irq,
    output logic          ack_err
);
    core_t core_d, core_q;

    logic          wr, rd;
    logic          wr_data, wr_ien, wr_ptr;
    logic          rd_data, rd_stat;
    logic          hold_valid;
    logic [DW-1:0] hold_data;
    logic          rx_take;
    logic          rx_avail;
    logic          tmr_expire;
    logic          tmr_cancel;
    logic          tx_pend;

    assign wr      = bus_valid && bus_we;
    assign rd      = bus_valid && !bus_we;
    assign wr_data = wr && (bus_addr == OFS_DATA);
    assign wr_ien  = wr && (bus_addr == OFS_IEN);
    assign wr_ptr  = wr && (bus_addr == OFS_PTR);
    assign rd_data = rd && (bus_addr == OFS_DATA);
    assign rd_stat = rd && (bus_addr == OFS_STAT);

    assign rx_ready   = rd_stat && !hold_valid;
    assign rx_take    = rx_ready && rx_valid;
    assign rx_avail   = hold_valid || rx_take;
    assign tmr_cancel = wr_ien && !bus_wdata[TXE_BIT];
    assign tx_pend    = core_q.tx_pend;

    cu_rx_hold #(.W(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (rx_take),
        .take_data (rx_data),
        .consume   (rd_data),
        .held      (hold_valid),
        .held_data (hold_data)
    );

    cu_txe_timer #(.DELAY(TX_DELAY)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_data),
        .cancel (tmr_cancel),
        .expire (tmr_expire)
    );

    cu_read_mux u_rmux (
        .rd_en     (rd),
        .addr      (bus_addr),
        .ier       (core_q.ier),
        .ptr       (core_q.ptr),
        .tx_pend   (core_q.tx_pend),
        .rx_avail  (rx_avail),
        .held_data (hold_data),
        .rdata     (bus_rdata)
    );

    always_comb begin
        core_d         = core_q;
        core_d.tx_vld  = 1'b0;
        core_d.ack_bad = 1'b0;
        if (wr_data) begin
            core_d.tx_pend = 1'b0;
            if (is_emittable(bus_wdata)) begin
                core_d.tx_vld  = 1'b1;
                core_d.tx_byte = bus_wdata;
            end
        end else if (wr_ien) begin
            core_d.ier     = bus_wdata;
            core_d.tx_pend = bus_wdata[TXE_BIT];
        end else if (wr_ptr) begin
            core_d.ptr = bus_wdata;
            if (bus_wdata == CMD_TX_ACK) begin
                core_d.ack_bad = !core_q.tx_pend;
                core_d.tx_pend = 1'b0;
            end
        end else if (tmr_expire && core_q.ier[TXE_BIT]) begin
            core_d.tx_pend = 1'b1;
        end
        if (rd_stat && (core_q.ptr == PTR_SRC)) begin
            core_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign tx_valid = core_q.tx_vld;
    assign tx_data  = core_q.tx_byte;
    assign ack_err  = core_q.ack_bad;
    assign irq      = core_q.tx_pend || hold_valid;
endmodule

// File: rtl/console_uart_chk.sv
module console_uart_chk
    import console_uart_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          tx_valid,
    input logic [DW-1:0] tx_data,
    input logic          ack_err,
    input logic          tx_pend,
    input logic          rx_held
);
    logic wr_at0, rd_at0, wr_at1, wr_at3, rd_at1, rd_at2;
    assign wr_at0 = bus_valid && bus_we && (bus_addr == OFS_DATA);
    assign rd_at0 = bus_valid && !bus_we && (bus_addr == OFS_DATA);
    assign wr_at1 = bus_valid && bus_we && (bus_addr == OFS_IEN);
    assign wr_at3 = bus_valid && bus_we && (bus_addr == OFS_PTR);
    assign rd_at1 = bus_valid && !bus_we && (bus_addr == OFS_IEN);
    assign rd_at2 = bus_valid && !bus_we && (bus_addr == OFS_IID);

    assert_rx_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_at0 |=> !rx_held);

    assert_tx_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_at0 && !bus_wdata[7] && bus_wdata != 8'h0C)
        |=> (tx_valid && tx_data == $past(bus_wdata)));

    assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_at0 && (bus_wdata[7] || bus_wdata == 8'h0C)) |=> !tx_valid);

    assert_tx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at0 |=> !tx_pend);

    assert_ien_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_at1 && bus_wdata[1]) |=> tx_pend);

    assert_ien_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_at1 && !bus_wdata[1]) |=> !tx_pend);

    assert_probe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_at1 |-> (bus_rdata == 8'h0F || bus_rdata == 8'h00));

    assert_iid_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_at2 |-> (bus_rdata[7:1] == 7'd0));

    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_at3 && bus_wdata == 8'h28) |=> !tx_pend);

    assert_ack_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_at3 && bus_wdata == 8'h28 && !tx_pend) |=> ack_err);
endmodule

bind console_uart_regs console_uart_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .ack_err   (ack_err),
    .tx_pend   (tx_pend),
    .rx_held   (hold_valid)
);

// File: tb/tb_console_uart_regs.sv
module tb_console_uart_regs;
    localparam int DLY = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid, irq, ack_err;
    logic [7:0] tx_data;

    int n_chk = 0, n_bad = 0;
    logic [7:0] r;

    always #4 clk = ~clk;

    console_uart_regs #(.TX_DELAY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq), .ack_err(ack_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
        chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
        chk("R1 ack_err", {7'd0, ack_err}, 8'h00);
        rd(3'd2, r); chk("R1 iid", r, 8'h01);
        rd(3'd1, r); chk("R1 ien", r, 8'h00);
        rd(3'd5, r); chk("R1 stat", r, 8'h64);
    endtask

    task automatic t_tx_forward;
        wr(3'd0, 8'h41);
        chk("R3 valid A", {7'd0, tx_valid}, 8'h01);
        chk("R3 data A", tx_data, 8'h41);
        @(posedge clk); #1;
        chk("R3 one-cycle", {7'd0, tx_valid}, 8'h00);
        wr(3'd0, 8'h0C); chk("R3 formfeed dropped", {7'd0, tx_valid}, 8'h00);
        wr(3'd0, 8'h80); chk("R3 high byte dropped", {7'd0, tx_valid}, 8'h00);
        wr(3'd0, 8'h0A); chk("R3 control sent", {7'd0, tx_valid}, 8'h01);
        chk("R3 control data", tx_data, 8'h0A);
        wr(3'd0, 8'h7F); chk("R3 0x7F sent", tx_data, 8'h7F);
        wr(3'd0, 8'hFF); chk("R3 0xFF dropped", {7'd0, tx_valid}, 8'h00);
    endtask

    task automatic t_timer;
        wr(3'd1, 8'h02); chk("R5 raise now", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h42); chk("R4 write clears", {7'd0, irq}, 8'h00);
        repeat (DLY - 1) @(posedge clk); #1;
        chk("R4 not yet", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R4 expiry sets", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h43);
        repeat (150) @(posedge clk);
        wr(3'd0, 8'h44);
        repeat (DLY - 1) @(posedge clk); #1;
        chk("R4 restart not yet", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R4 restart expiry", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h45);
        repeat (100) @(posedge clk);
        wr(3'd1, 8'h00); chk("R5 clear", {7'd0, irq}, 8'h00);
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h28);
        repeat (DLY + 5) @(posedge clk); #1;
        chk("R5 cancelled countdown", {7'd0, irq}, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h46);
        repeat (DLY + 2) @(posedge clk); #1;
        chk("R4 expiry gated by enable", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_probe;
        wr(3'd1, 8'h0F); rd(3'd1, r); chk("R6 0x0F", r, 8'h0F);
        wr(3'd1, 8'h07); rd(3'd1, r); chk("R6 0x07", r, 8'h00);
        wr(3'd1, 8'hFF); rd(3'd1, r); chk("R6 0xFF", r, 8'h00);
        wr(3'd1, 8'h00); rd(3'd2, r); chk("R7 idle", r, 8'h01);
    endtask

    task automatic t_ack;
        wr(3'd1, 8'h02);
        rd(3'd2, r); chk("R7 tx pending", r, 8'h00);
        wr(3'd3, 8'h28);
        chk("R8 ack clears", {7'd0, irq}, 8'h00);
        chk("R8 no error", {7'd0, ack_err}, 8'h00);
        wr(3'd3, 8'h28);
        chk("R8 error pulse", {7'd0, ack_err}, 8'h01);
        @(posedge clk); #1;
        chk("R8 error one cycle", {7'd0, ack_err}, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_rx;
        rx_valid = 1'b1; rx_data = 8'h5A;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 3'd5;
        #1 chk("R11 ready when empty", {7'd0, rx_ready}, 8'h01);
        chk("R10 stat with capture", bus_rdata, 8'h65);
        @(posedge clk); #1;
        bus_valid = 1'b0;
        rx_data = 8'h33;
        chk("R12 irq from rx", {7'd0, irq}, 8'h01);
        rd(3'd2, r); chk("R7 rx pending", r, 8'h00);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 3'd5;
        #1 chk("R11 not ready when held", {7'd0, rx_ready}, 8'h00);
        chk("R10 stat held", bus_rdata, 8'h65);
        @(posedge clk); #1;
        bus_valid = 1'b0; rx_valid = 1'b0;
        rd(3'd0, r); chk("R2 data", r, 8'h5A);
        chk("R2 cleared irq", {7'd0, irq}, 8'h00);
        rd(3'd5, r); chk("R2 stat after read", r, 8'h64);
    endtask

    task automatic t_ptr;
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h03); rd(3'd5, r); chk("R9 tx source", r, 8'h10);
        rd(3'd5, r); chk("R9 pointer reset", r, 8'h64);
        wr(3'd3, 8'h28); wr(3'd1, 8'h00);
        rx_valid = 1'b1; rx_data = 8'h61;
        rd(3'd5, r); rx_valid = 1'b0;
        wr(3'd3, 8'h03); rd(3'd5, r); chk("R9 rx source", r, 8'h20);
        rd(3'd0, r); chk("R2 second char", r, 8'h61);
        wr(3'd3, 8'h03); rd(3'd5, r); chk("R9 no source", r, 8'h00);
    endtask

    task automatic t_misc;
        wr(3'd1, 8'h0F);
        wr(3'd4, 8'hFF);
        rd(3'd1, r); chk("R12 mctl write ignored", r, 8'h0F);
        rd(3'd5, r); chk("R12 ptr untouched", r, 8'h64);
        rd(3'd4, r); chk("R12 read 4", r, 8'h00);
        rd(3'd6, r); chk("R12 read 6", r, 8'h00);
        rd(3'd7, r); chk("R12 read 7", r, 8'h00);
        rd(3'd3, r); chk("R12 read 3", r, 8'h00);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tx_forward();
        t_timer();
        t_probe();
        t_ack();
        t_rx();
        t_ptr();
        t_misc();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule